// File: doc/BRIEF.md
# Ratio Width Adapter (64-bit to 44-bit stream)

This block joins a 64-bit system stream to a 44-bit storage data path whose width does not divide the input width. It behaves as a small FIFO whose write side is 64 bits wide and whose read side is 44 bits wide. Incoming words are packed into a staging bank sized to the least common multiple of the two widths: 704 bits, held as eleven 64-bit slots. That bank holds exactly sixteen 44-bit output words, so one pass over the bank is one full repetition of the packing pattern.

Both sides use a valid/ready handshake. The block drops its input ready by itself whenever the bank lacks room for another full input word. It raises output valid only while a complete output word is buffered. The stream is packed least-significant bit first, so the output stream is a bit-exact re-slicing of the input stream. The same module, built with the widths swapped, serves as the 44-to-64 converter on the read-back side. Both clocks are the same: the block has a single clock domain.

Top module: `wxc_width_adapter`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the block empties. After that edge out_valid is 0 and in_ready is 1, and no partial word remaining from before the reset is ever emitted.
- R2: in_ready is 1 exactly when the number of buffered bits is at most the bank size minus the input width (704 - 64 = 640 by default). From empty with out_ready held low, exactly 11 input words are accepted before in_ready falls.
- R3: out_valid is 1 exactly when at least one output width of bits (44 by default) is buffered. From a full bank with in_valid held low, exactly 16 output words are delivered before out_valid falls.
- R4: Bits are packed least-significant first. Output word k carries bits 44k to 44k+43 of the concatenation of all accepted input words, with input word j occupying bits 64j to 64j+63.
- R5: While out_valid is 1 and out_ready is 0, the next cycle keeps out_valid at 1 and keeps out_data unchanged.
- R6: The pattern wraps without loss or duplication. After the last slot or the last output position, the write and read positions return to the start, and the stream stays bit-exact across many repetitions under any mix of backpressure on either side.
- R7: With in_valid and out_ready held at 1, once out_valid first rises it stays high on every cycle. Over any 176 consecutive cycles in that steady state, the input accepts 121 words within a margin of two (the input stalls 5 cycles in every 16).
- R8: Built with the input width 44 and the output width 64, the same module performs the inverse conversion. It obeys R1 to R6 with the same 704-bit bank and roles swapped: 16 inputs fill it and 11 outputs drain it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Bank has room for one full input word |
| in_data | input | IN_W (64) | Input word, packed least-significant bit first |
| out_valid | output | 1 | A complete output word is available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W (44) | Output word |

## Verification
Both in_ready and out_valid are functions of registered state only. A transfer taken at a rising edge therefore shows its effect on both flags, and on out_data, directly after that edge, and never within the same cycle. The bench drives inputs at the falling edge, waits a short settle time and then compares both flags against a bit-count model. That model is updated only for the transfers that the next rising edge will take, so each comparison uses the state that edge left behind. Output words are compared against a bit queue built from accepted input words at the cycle they are handed over. The stall-hold rule is checked one cycle after each refused output.

// File: rtl/wxc_pkg.sv
// Package: wxc_pkg
// Shared sizing helpers for the ratio width adapter. All functions are
// constant functions, used only to derive localparams at elaboration.
package wxc_pkg;

    // Greatest common divisor of two widths (Euclid).
    function automatic int unsigned wxc_gcd(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple: the bit size of one full packing pattern.
    function automatic int unsigned wxc_lcm(input int unsigned a, input int unsigned b);
        return (a / wxc_gcd(a, b)) * b;
    endfunction

    // Index width for a count of at least one entry, never zero bits wide.
    function automatic int unsigned wxc_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wxc_ctrl.sv
// Module: wxc_ctrl
// FIFO-style control for the width adapter: keeps the write slot, the read
// position and the number of buffered bits, and derives both handshake
// flags from that registered state alone (no input-to-output comb path).
// Assumes IN_W and OUT_W each divide the pattern size CAP exactly, which
// holds by construction since CAP is their least common multiple.
module wxc_ctrl
    import wxc_pkg::*;
#(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 44
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              out_ready,
    output logic                              in_ready,
    output logic                              out_valid,
    output logic                              push,
    output logic [wxc_idx_w(wxc_lcm(IN_W, OUT_W) / IN_W)-1:0]  wr_slot,
    output logic [wxc_idx_w(wxc_lcm(IN_W, OUT_W) / OUT_W)-1:0] rd_slot
);
    localparam int unsigned CAP   = wxc_lcm(IN_W, OUT_W);
    localparam int unsigned N_IN  = CAP / IN_W;
    localparam int unsigned N_OUT = CAP / OUT_W;
    localparam int unsigned WPW   = wxc_idx_w(N_IN);
    localparam int unsigned RPW   = wxc_idx_w(N_OUT);
    localparam int unsigned FW    = $clog2(CAP + 1);
    localparam logic [FW-1:0]  ROOM_LIMIT = FW'(CAP - IN_W);
    localparam logic [FW-1:0]  WORD_OUT   = FW'(OUT_W);
    localparam logic [FW-1:0]  STEP_IN    = FW'(IN_W);
    localparam logic [FW-1:0]  STEP_OUT   = FW'(OUT_W);
    localparam logic [WPW-1:0] WR_LAST    = WPW'(N_IN - 1);
    localparam logic [RPW-1:0] RD_LAST    = RPW'(N_OUT - 1);

    logic [FW-1:0] fill_q;
    logic          pop;

    // Handshake flags derived from the registered fill level only.
    always_comb begin
        in_ready  = (fill_q <= ROOM_LIMIT);
        out_valid = (fill_q >= WORD_OUT);
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
    end

    // Advance the write slot on each accepted input word, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
        end else if (push) begin
            wr_slot <= (wr_slot == WR_LAST) ? '0 : wr_slot + 1'b1;
        end
    end

    // Advance the read position on each delivered output word, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= '0;
        end else if (pop) begin
            rd_slot <= (rd_slot == RD_LAST) ? '0 : rd_slot + 1'b1;
        end
    end

    // Track the number of buffered bits across pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   fill_q <= fill_q + STEP_IN;
                2'b01:   fill_q <= fill_q - STEP_OUT;
                2'b11:   fill_q <= fill_q + STEP_IN - STEP_OUT;
                default: fill_q <= fill_q;
            endcase
        end
    end

    // R1: a reset edge leaves the block empty with room for input.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R2: the fill level never exceeds the bank size.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(CAP));

    // R6: the write slot returns to zero after the last slot is written.
    assert_wr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_slot == WR_LAST) |=> (wr_slot == '0));

    // R6: the read position returns to zero after the last word is delivered.
    assert_rd_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && rd_slot == RD_LAST) |=> (rd_slot == '0));

endmodule

// File: rtl/wxc_store.sv
// Module: wxc_store
// Staging bank of CAP/IN_W input-width slots. The slot selected by the
// write position is loaded on an accepted input word. The bank is exposed
// flat with slot 0 in the least significant bits. Data slots carry no
// reset: the control block guarantees no unwritten bit is ever presented
// as valid output.
module wxc_store
    import wxc_pkg::*;
#(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 44
) (
    input  logic                                              clk,
    input  logic                                              push,
    input  logic [wxc_idx_w(wxc_lcm(IN_W, OUT_W) / IN_W)-1:0] wr_slot,
    input  logic [IN_W-1:0]                                   in_data,
    output logic [wxc_lcm(IN_W, OUT_W)-1:0]                   bank_flat
);
    localparam int unsigned CAP  = wxc_lcm(IN_W, OUT_W);
    localparam int unsigned N_IN = CAP / IN_W;
    localparam int unsigned WPW  = wxc_idx_w(N_IN);

    for (genvar i = 0; i < N_IN; i++) begin : g_slot
        logic [IN_W-1:0] slot_q;

        // Load this slot when it is the current write target.
        always_ff @(posedge clk) begin
            if (push && (wr_slot == WPW'(i))) begin
                slot_q <= in_data;
            end
        end

        assign bank_flat[i*IN_W +: IN_W] = slot_q;
    end

endmodule

// File: rtl/wxc_extract.sv
// Module: wxc_extract
// Output selector: splits the flat bank into CAP/OUT_W output-width words
// and presents the one at the read position. Purely combinational.
module wxc_extract
    import wxc_pkg::*;
#(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 44
) (
    input  logic [wxc_lcm(IN_W, OUT_W)-1:0]                    bank_flat,
    input  logic [wxc_idx_w(wxc_lcm(IN_W, OUT_W) / OUT_W)-1:0] rd_slot,
    output logic [OUT_W-1:0]                                   out_data
);
    localparam int unsigned CAP   = wxc_lcm(IN_W, OUT_W);
    localparam int unsigned N_OUT = CAP / OUT_W;
    localparam int unsigned RPW   = wxc_idx_w(N_OUT);

    logic [OUT_W-1:0] words [N_OUT];

    for (genvar j = 0; j < N_OUT; j++) begin : g_word
        assign words[j] = bank_flat[j*OUT_W +: OUT_W];
    end

    // Select the output word at the current read position.
    always_comb begin
        out_data = '0;
        for (int j = 0; j < N_OUT; j++) begin
            if (rd_slot == RPW'(j)) begin
                out_data = words[j];
            end
        end
    end

endmodule

// File: rtl/wxc_width_adapter.sv
// Module: wxc_width_adapter
// Top of the ratio width adapter: a FIFO with an IN_W-bit write port and
// an OUT_W-bit read port over a bank of lcm(IN_W, OUT_W) bits. Default is
// 64 in, 44 out; swapping the widths gives the inverse converter.
// Assumes one clock domain and a synchronous active-low reset.
module wxc_width_adapter
    import wxc_pkg::*;
#(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam int unsigned CAP   = wxc_lcm(IN_W, OUT_W);
    localparam int unsigned N_IN  = CAP / IN_W;
    localparam int unsigned N_OUT = CAP / OUT_W;
    localparam int unsigned WPW   = wxc_idx_w(N_IN);
    localparam int unsigned RPW   = wxc_idx_w(N_OUT);

    logic           push;
    logic [WPW-1:0] wr_slot;
    logic [RPW-1:0] rd_slot;
    logic [CAP-1:0] bank_flat;

    wxc_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .push      (push),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot)
    );

    wxc_store #(.IN_W(IN_W), .OUT_W(OUT_W)) store_i (
        .clk       (clk),
        .push      (push),
        .wr_slot   (wr_slot),
        .in_data   (in_data),
        .bank_flat (bank_flat)
    );

    wxc_extract #(.IN_W(IN_W), .OUT_W(OUT_W)) extract_i (
        .bank_flat (bank_flat),
        .rd_slot   (rd_slot),
        .out_data  (out_data)
    );

    // R5: a refused output word stays valid and unchanged on the next cycle.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/wxc_width_adapter_tb.sv
// Bench: drives the 64->44 adapter (dut_i) and a 44->64 instance (rev_i)
// with swept valid/ready densities, checking flags against a bit-count
// model and data against a bit-queue scoreboard.
module wxc_width_adapter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 704;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [63:0] in_data = '0;
    logic [43:0] out_data;
    logic        r_in_valid = 1'b0, r_in_ready, r_out_valid, r_out_ready = 1'b0;
    logic [43:0] r_in_data = '0;
    logic [63:0] r_out_data;

    wxc_width_adapter #(.IN_W(64), .OUT_W(44)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data));

    wxc_width_adapter #(.IN_W(44), .OUT_W(64)) rev_i (
        .clk(clk), .rst_n(rst_n), .in_valid(r_in_valid), .in_ready(r_in_ready),
        .in_data(r_in_data), .out_valid(r_out_valid), .out_ready(r_out_ready),
        .out_data(r_out_data));

    int  n_checks = 0, n_fails = 0;
    bit  done = 1'b0;
    int  fill_m = 0, r_fill_m = 0;
    bit  sb[$];
    bit  rsb[$];
    bit  stall_prev = 1'b0, r_stall_prev = 1'b0;
    logic [63:0] stall_data = '0, r_stall_data = '0;
    int  in_fires = 0, out_fires = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        r_in_valid = 1'b0; r_out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fill_m = 0; r_fill_m = 0;
        sb.delete(); rsb.delete();
        stall_prev = 1'b0; r_stall_prev = 1'b0;
        #1;
        chk(!out_valid && in_ready, "R1", "forward flags after reset",
            {62'd0, out_valid, in_ready}, 64'd1);
        chk(!r_out_valid && r_in_ready, "R1", "reverse flags after reset",
            {62'd0, r_out_valid, r_in_ready}, 64'd1);
    endtask

    // One cycle: drive at negedge, settle, check, update models for the next edge.
    task automatic step(input int pin, input int pout);
        logic [43:0] exp44;
        logic [63:0] exp64;
        @(negedge clk);
        in_valid    = ($urandom_range(99) < pin);
        in_data     = {$urandom, $urandom};
        out_ready   = ($urandom_range(99) < pout);
        r_in_valid  = ($urandom_range(99) < pin);
        r_in_data   = 44'({$urandom, $urandom});
        r_out_ready = ($urandom_range(99) < pout);
        #1;
        // R2/R3 forward flags against the bit-count model
        chk(in_ready == (fill_m <= CAP - 64), "R2", "forward in_ready", 64'(in_ready), 64'(fill_m <= CAP - 64));
        chk(out_valid == (fill_m >= 44), "R3", "forward out_valid", 64'(out_valid), 64'(fill_m >= 44));
        // R8 reverse flags
        chk(r_in_ready == (r_fill_m <= CAP - 44), "R8", "reverse in_ready", 64'(r_in_ready), 64'(r_fill_m <= CAP - 44));
        chk(r_out_valid == (r_fill_m >= 64), "R8", "reverse out_valid", 64'(r_out_valid), 64'(r_fill_m >= 64));
        // R5 hold after a refused word
        if (stall_prev)
            chk(out_valid && out_data == stall_data[43:0], "R5", "forward hold", 64'(out_data), stall_data);
        if (r_stall_prev)
            chk(r_out_valid && r_out_data == r_stall_data, "R8", "reverse hold", r_out_data, r_stall_data);
        stall_prev   = out_valid && !out_ready;
        stall_data   = 64'(out_data);
        r_stall_prev = r_out_valid && !r_out_ready;
        r_stall_data = r_out_data;
        // Scoreboard: forward (R4, R6)
        if (in_valid && in_ready) begin
            for (int b = 0; b < 64; b++) sb.push_back(in_data[b]);
            fill_m += 64;
            in_fires++;
        end
        if (out_valid && out_ready) begin
            exp44 = '0;
            if (sb.size() >= 44) begin
                for (int b = 0; b < 44; b++) exp44[b] = sb.pop_front();
                chk(out_data == exp44, "R4", "forward word (R6 stream)", 64'(out_data), 64'(exp44));
            end else begin
                chk(1'b0, "R4", "forward word without data", 64'(out_data), 64'd0);
            end
            fill_m -= 44;
            out_fires++;
        end
        // Scoreboard: reverse (R8)
        if (r_in_valid && r_in_ready) begin
            for (int b = 0; b < 44; b++) rsb.push_back(r_in_data[b]);
            r_fill_m += 44;
        end
        if (r_out_valid && r_out_ready) begin
            exp64 = '0;
            if (rsb.size() >= 64) begin
                for (int b = 0; b < 64; b++) exp64[b] = rsb.pop_front();
                chk(r_out_data == exp64, "R8", "reverse word", r_out_data, exp64);
            end else begin
                chk(1'b0, "R8", "reverse word without data", r_out_data, 64'd0);
            end
            r_fill_m -= 64;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int streak;
        do_reset();

        // R2: fill from empty with no output taken: exactly 11 words accepted.
        in_fires = 0;
        for (int c = 0; c < 30; c++) step(100, 0);
        chk(in_fires == 11, "R2", "words accepted into empty bank", 64'(in_fires), 64'd11);

        // R3: drain with no input: exactly 16 output words.
        out_fires = 0;
        for (int c = 0; c < 30; c++) step(0, 100);
        chk(out_fires == 16, "R3", "words drained from full bank", 64'(out_fires), 64'd16);

        // R4/R5/R6/R8: sweep of input and output densities.
        for (int pi = 0; pi < 3; pi++) begin
            for (int po = 0; po < 5; po++) begin
                for (int c = 0; c < 1200; c++) step((pi == 2) ? 100 : 25 + 25 * pi, 25 * po);
            end
        end

        // R1: reset in the middle of a partially filled bank.
        for (int c = 0; c < 5; c++) step(100, 0);
        do_reset();
        for (int c = 0; c < 3; c++) step(0, 100);
        chk(out_fires >= 0 && sb.size() == 0, "R1", "no stale word after reset", 64'(sb.size()), 64'd0);

        // R7: steady streaming throughput.
        do_reset();
        for (int c = 0; c < 64; c++) step(100, 100);
        in_fires = 0; out_fires = 0; streak = 0;
        for (int c = 0; c < 176; c++) begin
            step(100, 100);
            if (out_valid) streak++;
        end
        chk(streak == 176, "R7", "out_valid held every cycle", 64'(streak), 64'd176);
        chk(in_fires >= 119 && in_fires <= 123, "R7", "inputs per 176 cycles", 64'(in_fires), 64'd121);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule